// File: doc/BRIEF.md
# SPI Word Queue with Threshold Interrupts

This block buffers 32-bit words between a register-side agent and an SPI shift engine. A transmit queue collects words from the register side and hands them to the engine. A receive queue collects words the engine delivers and holds them until the register side reads them. Each queue holds eight words. Each queue reports a live fill count and full and empty flags.

Both queues feed a set of status bits: two threshold comparisons, a sticky overrun flag and a receive timeout flag. Each status bit has its own enable, and the enabled bits are combined into a single interrupt line. In queue mode the block drives the engine's busy indication by itself. No explicit start command is needed, because writing a word is enough to start the engine.

Back-pressure: the register side may write only while `tx_in_ready` is high, and `tx_in_ready` is low exactly when the transmit queue is full. The engine takes a word when `tx_out_valid` and `tx_out_ready` are both high. The register side takes a received word when `rx_out_valid` and `rx_out_ready` are both high. The engine's delivery path has no ready signal. A word that arrives when the receive queue has no room is lost, and the overrun flag records the loss.

Top module: `spi_fifo_buf`

## Requirements
- R1: Each queue holds 8 words and returns them in first-in first-out order. Its count runs from 0 to 8. Full means count 8 and empty means count 0. `tx_in_ready` is the inverse of `tx_full`.
- R2: A push and a pop accepted in the same cycle leave the count unchanged. A pop from an empty queue leaves the count at 0. `rx_out_data` reads 0 while the receive queue is empty.
- R3: `rx_thr_sts` is 1 exactly when `rx_count` is strictly greater than the 2-bit `rx_thresh`, compared as an unsigned number.
- R4: `tx_thr_sts` is 1 exactly when `tx_count` is less than or equal to the 2-bit `tx_thresh`.
- R5: A word may arrive on `rx_in_valid` while the receive queue is full and no pop happens in that cycle. That word is discarded and `ovr_flag` is set. The flag stays set until a cycle with `ovr_clr` high and no new overrun; if both happen in one cycle, the set wins.
- R6: A `tx_flush` or `rx_flush` pulse empties its queue on the next edge. A push in the same cycle as the flush is discarded and does not count as an overrun.
- R7: `tmo_flag` rises on the 64th `sclk_tick` counted while the receive queue is non-empty and is neither popped nor flushed. Any pop or flush clears the flag and restarts the count. `tmo_clr` also clears the flag, but the count is not restarted, so the flag cannot set again until the next pop.
- R8: `busy` is 1 exactly when `fifo_mode` is 1 and either the transmit queue is non-empty or a word handed to the engine is still in flight. A word is in flight from its handshake until `xfer_done`. `tx_out_valid` is 1 only in queue mode with a non-empty transmit queue.
- R9: `irq` is the OR of `rx_thr_sts & ie_rx`, `tx_thr_sts & ie_tx`, `ovr_flag & ie_ovr` and `tmo_flag & ie_tmo`.
- R10: After reset both counts are 0, both queues read empty and not full, and `ovr_flag`, `tmo_flag` and `busy` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_mode | input | 1 | Enables queue mode: transmit words go out and busy is generated automatically |
| tx_in_valid | input | 1 | Register side offers a transmit word |
| tx_in_ready | output | 1 | Transmit queue has room |
| tx_in_data | input | 32 | Transmit word from the register side |
| tx_out_valid | output | 1 | Head transmit word is offered to the engine |
| tx_out_ready | input | 1 | Engine takes the head word |
| tx_out_data | output | 32 | Head transmit word |
| xfer_done | input | 1 | Engine has finished shifting the word it took |
| rx_in_valid | input | 1 | Engine delivers a received word |
| rx_in_data | input | 32 | Received word from the engine |
| rx_out_valid | output | 1 | Receive queue holds a word |
| rx_out_ready | input | 1 | Register side reads the head received word |
| rx_out_data | output | 32 | Head received word, 0 when the queue is empty |
| tx_flush | input | 1 | Pulse that empties the transmit queue |
| rx_flush | input | 1 | Pulse that empties the receive queue |
| sclk_tick | input | 1 | One pulse per SPI clock period |
| rx_thresh | input | 2 | Receive threshold level |
| tx_thresh | input | 2 | Transmit threshold level |
| ovr_clr | input | 1 | Clears the overrun flag |
| tmo_clr | input | 1 | Clears the timeout flag |
| ie_rx | input | 1 | Enables the receive threshold interrupt |
| ie_tx | input | 1 | Enables the transmit threshold interrupt |
| ie_ovr | input | 1 | Enables the overrun interrupt |
| ie_tmo | input | 1 | Enables the timeout interrupt |
| tx_count | output | 4 | Number of words in the transmit queue |
| rx_count | output | 4 | Number of words in the receive queue |
| tx_full | output | 1 | Transmit queue full |
| tx_empty | output | 1 | Transmit queue empty |
| rx_full | output | 1 | Receive queue full |
| rx_empty | output | 1 | Receive queue empty |
| rx_thr_sts | output | 1 | Receive count is above the threshold |
| tx_thr_sts | output | 1 | Transmit count is at or below the threshold |
| ovr_flag | output | 1 | Sticky receive overrun flag |
| tmo_flag | output | 1 | Receive timeout flag |
| busy | output | 1 | Engine busy in queue mode |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions check these rules on every cycle:
- the counts never exceed the depth;
- a flush leaves the queue empty;
- a push paired with a pop holds the count;
- a pop from an empty queue does not underflow;
- an overrun sets its flag and the flag holds until cleared;
- a timeout rises only after a tick with data present;
- a write in queue mode raises busy.

Other behaviour needs the bench's scenarios. That covers first-in first-out data order, the exact tick on which the timeout fires, the asymmetric threshold comparisons across different threshold settings, and interrupt masking. The bench checks these by comparing every output against a queue model on every cycle, under random traffic mixes that fill the queues, drain them and starve them.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;
  localparam int unsigned WORD_W     = 32;
  localparam int unsigned FIFO_DEPTH = 8;
  localparam int unsigned TMO_TICKS  = 64;
  localparam int unsigned THR_W      = 2;

  function automatic int unsigned count_width(input int unsigned depth);
    return $clog2(depth + 1);
  endfunction
endpackage

// File: rtl/spi_sync_fifo.sv
module spi_sync_fifo #(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  head_data,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty,
  output logic          drop
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign do_pop  = pop && !empty;
  assign do_push = push && (!full || do_pop);
  assign drop    = push && !do_push && !flush;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= ptr_inc(wr_ptr);
      if (do_pop)  rd_ptr <= ptr_inc(rd_ptr);
      if (do_push && !do_pop)      count <= count + 1'b1;
      else if (do_pop && !do_push) count <= count - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wr_ptr] <= push_data;
  end

  assign head_data = empty ? '0 : mem[rd_ptr];

  p_count_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  p_flush_empties_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count == '0));
  p_push_pop_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop && !empty && !flush) |=> $stable(count));
  p_no_underflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push) |=> (count == '0));
endmodule

// File: rtl/spi_rx_timeout.sv
module spi_rx_timeout #(
  parameter int unsigned LIMIT = 64,
  localparam int unsigned CW   = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic restart,
  input  logic tick,
  input  logic clr,
  output logic flag
);
  logic [CW-1:0] ticks;
  logic          hold_zero, hit;

  assign hold_zero = restart || !active;
  assign hit       = !hold_zero && tick && (ticks == CW'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                ticks <= '0;
    else if (hold_zero)                        ticks <= '0;
    else if (tick && (ticks != CW'(LIMIT)))    ticks <= ticks + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              flag <= 1'b0;
    else if (hit)            flag <= 1'b1;
    else if (restart || clr) flag <= 1'b0;
  end

  p_tmo_needs_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> ($past(active) && $past(tick)));
  p_tmo_cleared_by_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !flag);
endmodule

// File: rtl/spi_fifo_buf.sv
module spi_fifo_buf
  import spi_fifo_pkg::*;
#(
  parameter int unsigned W      = WORD_W,
  parameter int unsigned DEPTH  = FIFO_DEPTH,
  parameter int unsigned TICKS  = TMO_TICKS,
  parameter int unsigned TW     = THR_W,
  localparam int unsigned CW    = count_width(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_mode,
  input  logic          tx_in_valid,
  output logic          tx_in_ready,
  input  logic [W-1:0]  tx_in_data,
  output logic          tx_out_valid,
  input  logic          tx_out_ready,
  output logic [W-1:0]  tx_out_data,
  input  logic          xfer_done,
  input  logic          rx_in_valid,
  input  logic [W-1:0]  rx_in_data,
  output logic          rx_out_valid,
  input  logic          rx_out_ready,
  output logic [W-1:0]  rx_out_data,
  input  logic          tx_flush,
  input  logic          rx_flush,
  input  logic          sclk_tick,
  input  logic [TW-1:0] rx_thresh,
  input  logic [TW-1:0] tx_thresh,
  input  logic          ovr_clr,
  input  logic          tmo_clr,
  input  logic          ie_rx,
  input  logic          ie_tx,
  input  logic          ie_ovr,
  input  logic          ie_tmo,
  output logic [CW-1:0] tx_count,
  output logic [CW-1:0] rx_count,
  output logic          tx_full,
  output logic          tx_empty,
  output logic          rx_full,
  output logic          rx_empty,
  output logic          rx_thr_sts,
  output logic          tx_thr_sts,
  output logic          ovr_flag,
  output logic          tmo_flag,
  output logic          busy,
  output logic          irq
);
  logic tx_push, tx_pop, rx_pop, rx_drop, tx_drop_unused, in_flight;

  assign tx_in_ready  = !tx_full;
  assign tx_push      = tx_in_valid && tx_in_ready;
  assign tx_out_valid = fifo_mode && !tx_empty;
  assign tx_pop       = tx_out_valid && tx_out_ready;
  assign rx_out_valid = !rx_empty;
  assign rx_pop       = rx_out_valid && rx_out_ready;

  spi_sync_fifo #(.W(W), .DEPTH(DEPTH)) u_tx_q (
    .clk(clk), .rst_n(rst_n), .flush(tx_flush),
    .push(tx_push), .push_data(tx_in_data), .pop(tx_pop),
    .head_data(tx_out_data), .count(tx_count),
    .full(tx_full), .empty(tx_empty), .drop(tx_drop_unused)
  );

  spi_sync_fifo #(.W(W), .DEPTH(DEPTH)) u_rx_q (
    .clk(clk), .rst_n(rst_n), .flush(rx_flush),
    .push(rx_in_valid), .push_data(rx_in_data), .pop(rx_pop),
    .head_data(rx_out_data), .count(rx_count),
    .full(rx_full), .empty(rx_empty), .drop(rx_drop)
  );

  spi_rx_timeout #(.LIMIT(TICKS)) u_tmo (
    .clk(clk), .rst_n(rst_n), .active(!rx_empty),
    .restart(rx_pop || rx_flush), .tick(sclk_tick),
    .clr(tmo_clr), .flag(tmo_flag)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ovr_flag <= 1'b0;
    else if (rx_drop) ovr_flag <= 1'b1;
    else if (ovr_clr) ovr_flag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         in_flight <= 1'b0;
    else if (tx_pop)    in_flight <= 1'b1;
    else if (xfer_done) in_flight <= 1'b0;
  end

  assign busy       = fifo_mode && (!tx_empty || in_flight);
  assign rx_thr_sts = rx_count >  CW'(rx_thresh);
  assign tx_thr_sts = tx_count <= CW'(tx_thresh);
  assign irq = (rx_thr_sts && ie_rx) || (tx_thr_sts && ie_tx)
            || (ovr_flag && ie_ovr) || (tmo_flag && ie_tmo);

  p_ovr_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_in_valid && rx_full && !rx_out_ready && !rx_flush) |=> ovr_flag);
  p_ovr_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_flag && !ovr_clr) |=> ovr_flag);
  p_busy_on_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_mode && tx_push && !tx_flush) |=> (busy || !fifo_mode));
  p_ready_when_full_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_full && !tx_flush && !tx_pop) |=> !tx_in_ready);
endmodule

// File: tb/spi_fifo_buf_tb.sv
`timescale 1ns/1ps
module spi_fifo_buf_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic fifo_mode = 0, tx_in_valid = 0, tx_out_ready = 0, xfer_done = 0;
  logic rx_in_valid = 0, rx_out_ready = 0, tx_flush = 0, rx_flush = 0;
  logic sclk_tick = 0, ovr_clr = 0, tmo_clr = 0;
  logic ie_rx = 0, ie_tx = 0, ie_ovr = 0, ie_tmo = 0;
  logic [31:0] tx_in_data = 0, rx_in_data = 0;
  logic [1:0] rx_thresh = 0, tx_thresh = 0;
  logic tx_in_ready, tx_out_valid, rx_out_valid;
  logic [31:0] tx_out_data, rx_out_data;
  logic [3:0] tx_count, rx_count;
  logic tx_full, tx_empty, rx_full, rx_empty, rx_thr_sts, tx_thr_sts;
  logic ovr_flag, tmo_flag, busy, irq;

  spi_fifo_buf u_dut (.*);

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] tq[$], rq[$];
  bit m_ovr = 0, m_tmo = 0, m_fly = 0;
  int m_ticks = 0;
  bit last_tflush = 0, last_rflush = 0, last_both = 0;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit pct(input int p);
    return ($urandom % 100) < p;
  endfunction

  task automatic compare_all();
    logic [31:0] rhead, thead;
    bit ethr_rx, ethr_tx, eirq;
    rhead = (rq.size() > 0) ? rq[0] : 32'h0;
    thead = (tq.size() > 0) ? tq[0] : 32'h0;
    chk("R1", "tx_count", 32'(tx_count), 32'(tq.size()));
    chk("R1", "rx_count", 32'(rx_count), 32'(rq.size()));
    chk("R1", "tx_full",  32'(tx_full),  32'(tq.size() == 8));
    chk("R1", "tx_empty", 32'(tx_empty), 32'(tq.size() == 0));
    chk("R1", "rx_full",  32'(rx_full),  32'(rq.size() == 8));
    chk("R1", "rx_empty", 32'(rx_empty), 32'(rq.size() == 0));
    chk("R1", "tx_in_ready", 32'(tx_in_ready), 32'(tq.size() != 8));
    if (rq.size() == 0) chk("R2", "rx_out_data empty", rx_out_data, 32'h0);
    else                chk("R1", "rx_out_data order", rx_out_data, rhead);
    if (tx_out_valid) chk("R1", "tx_out_data order", tx_out_data, thead);
    if (last_both) chk("R2", "count after push+pop", 32'(rx_count), 32'(rq.size()));
    if (last_tflush) chk("R6", "tx flush", 32'(tx_count), 32'(tq.size()));
    if (last_rflush) chk("R6", "rx flush", 32'(rx_count), 32'(rq.size()));
    ethr_rx = rq.size() > int'(rx_thresh);
    ethr_tx = tq.size() <= int'(tx_thresh);
    chk("R3", "rx_thr_sts", 32'(rx_thr_sts), 32'(ethr_rx));
    chk("R4", "tx_thr_sts", 32'(tx_thr_sts), 32'(ethr_tx));
    chk("R5", "ovr_flag", 32'(ovr_flag), 32'(m_ovr));
    chk("R7", "tmo_flag", 32'(tmo_flag), 32'(m_tmo));
    chk("R8", "busy", 32'(busy), 32'(fifo_mode && (tq.size() > 0 || m_fly)));
    chk("R8", "tx_out_valid", 32'(tx_out_valid), 32'(fifo_mode && tq.size() > 0));
    eirq = (ethr_rx && ie_rx) || (ethr_tx && ie_tx) || (m_ovr && ie_ovr) || (m_tmo && ie_tmo);
    chk("R9", "irq", 32'(irq), 32'(eirq));
  endtask

  task automatic model_step();
    bit tpush, tpop, rpop, rpush, restart, hold, hit;
    int rsz;
    tpush = tx_in_valid && tq.size() < 8;
    tpop  = fifo_mode && tq.size() > 0 && tx_out_ready;
    rpop  = rx_out_ready && rq.size() > 0;
    rsz   = rq.size();
    restart = rpop || rx_flush;
    hold = restart || rsz == 0;
    hit  = !hold && sclk_tick && m_ticks == 63;
    if (hold) m_ticks = 0;
    else if (sclk_tick && m_ticks != 64) m_ticks++;
    if (hit) m_tmo = 1;
    else if (restart || tmo_clr) m_tmo = 0;
    if (tpop) m_fly = 1; else if (xfer_done) m_fly = 0;
    if (tx_flush) tq.delete();
    else begin
      if (tpop) void'(tq.pop_front());
      if (tpush) tq.push_back(tx_in_data);
    end
    last_both = 0;
    if (rx_flush) rq.delete();
    else begin
      rpush = rx_in_valid && (rsz < 8 || rpop);
      last_both = rpush && rpop;
      if (rpop) void'(rq.pop_front());
      if (rpush) rq.push_back(rx_in_data);
      if (rx_in_valid && !rpush) m_ovr = 1;
      else if (ovr_clr) m_ovr = 0;
    end
    if (rx_flush && ovr_clr) m_ovr = 0;
    last_tflush = tx_flush;
    last_rflush = rx_flush;
  endtask

  task automatic run_phase(input int n, input bit mode, input int p_tv, input int p_tr,
                           input int p_rv, input int p_rr, input int p_tick, input int p_fl);
    fifo_mode = mode;
    rx_thresh = 2'($urandom); tx_thresh = 2'($urandom);
    {ie_rx, ie_tx, ie_ovr, ie_tmo} = 4'($urandom);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare_all();
      tx_in_valid = pct(p_tv);  tx_in_data = $urandom;
      tx_out_ready = pct(p_tr); xfer_done = pct(30);
      rx_in_valid = pct(p_rv);  rx_in_data = $urandom;
      rx_out_ready = pct(p_rr); sclk_tick = pct(p_tick);
      tx_flush = pct(p_fl); rx_flush = pct(p_fl);
      ovr_clr = pct(3); tmo_clr = pct(2);
      if (pct(5)) begin rx_thresh = 2'($urandom); tx_thresh = 2'($urandom); end
      model_step();
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10", "tx_count", 32'(tx_count), 0);
    chk("R10", "rx_empty", 32'(rx_empty), 1);
    chk("R10", "tx_full", 32'(tx_full), 0);
    chk("R10", "flags", 32'({ovr_flag, tmo_flag, busy}), 0);
    rst_n = 1;
    run_phase(60, 0, 80, 0, 0, 0, 0, 0);     // fill tx with engine idle: full, no ready
    run_phase(600, 1, 50, 50, 60, 40, 20, 2); // mixed traffic
    run_phase(400, 1, 30, 60, 90, 10, 10, 1); // overrun pressure
    run_phase(300, 1, 10, 80, 15, 0, 100, 0); // starved reads: timeout
    run_phase(100, 1, 0, 100, 0, 100, 50, 0); // drain and read empty
    run_phase(800, 1, 40, 40, 40, 40, 60, 1); // mixed again
    @(negedge clk);
    compare_all();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule